// File: doc/BRIEF.md
# Lockable Channel Trigger Router

The block routes trigger events across a small set of broadcast channels. Each channel carries one-cycle pulses. A channel pulse can come in from a shared channel bus, or software can raise it through a register write. Every local trigger output has its own channel-select register. An output fires in any cycle in which one of its selected channels is active. Pulses raised locally by software leave on the outgoing channel bus only through a per-channel gate.

All configuration sits behind a word-addressed register port with a registered read path. A key register protects that configuration. Out of reset the block is locked, and every write other than one to the key register is dropped. Writing the exact key opens the port. Writing any other value to the key register closes it again. A global enable bit in the control register silences every output while it is clear.

Top module: `xtrig_hub`

## Requirements
- R1: While the port is locked, writes to any offset other than the key register (0xFB0) leave every register unchanged and raise no software pulse.
- R2: Writing 0xC5ACCE55 to offset 0xFB0 unlocks the port. Writing any other value there locks it again.
- R3: Bit 0 of the control register (offset 0x000) enables the block. While it is 0, no trigger output and no outgoing channel bit asserts.
- R4: Trigger output n has a channel-select register at offset 0x0A0 + 4*n. Bit k set makes output n assert for each cycle in which channel k is active. A `chan_in` bit sampled at a clock edge shows on `trig_out` right after that same edge.
- R5: The gate register at offset 0x140 has one bit per channel. A software pulse on channel k appears on `chan_out` only when gate bit k is 1. Incoming `chan_in` pulses are never echoed to `chan_out`.
- R6: Writing the pulse register (offset 0x01C) with bit k set pulses channel k for exactly one cycle. The pulse shows on `chan_out` and on the mapped `trig_out` bits right after the clock edge that follows the write edge.
- R7: The channel state seen by the trigger outputs is the OR of the incoming `chan_in` bits and the local software pulse of the same cycle.
- R8: Reads return the current register values whether the port is locked or not, one cycle after the address is presented. Register bits above the channel count read 0. Unmapped offsets, the key register and the pulse register read 0.
- R9: After reset the port is locked, the control, gate and channel-select registers hold 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (12) | Byte offset for read and write |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Registered read data for the previous cycle's address |
| chan_in | input | NCH (4) | Incoming channel pulses from the shared bus |
| chan_out | output | NCH (4) | Gated local channel pulses to the shared bus |
| trig_out | output | NTRIG (14) | Local trigger outputs |

## Verification
The checks assume that `chan_in` pulses last one cycle. They also assume that the register port issues at most one write per cycle, at a word-aligned offset. The stimulus changes inputs only on the falling clock edge and leaves idle cycles between writes, so each software pulse stands alone. The one-cycle properties tie an idle pulse register to a quiet outgoing bus two cycles later, so they do not depend on the write pattern. The gate check compares each outgoing bit with the gate value of the previous cycle.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam logic [31:0] UNLOCK_KEY  = 32'hC5AC_CE55;
  localparam int          OFF_CTRL    = 'h000;
  localparam int          OFF_PULSE   = 'h01C;
  localparam int          OFF_EN_BASE = 'h0A0;
  localparam int          OFF_GATE    = 'h140;
  localparam int          OFF_LOCK    = 'hFB0;
endpackage

// File: rtl/xtrig_lock.sv
module xtrig_lock #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          locked_o
);
  import xtrig_pkg::*;

  logic key_hit;
  logic locked_q;

  assign key_hit  = wr_en && (wr_addr == AW'(OFF_LOCK));
  assign locked_o = locked_q;

  always_ff @(posedge clk) begin
    if (rst)          locked_q <= 1'b1;
    else if (key_hit) locked_q <= (wr_data[31:0] != UNLOCK_KEY);
  end

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (key_hit && wr_data[31:0] == UNLOCK_KEY) |=> !locked_o); // R2
  AST_BADKEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (key_hit && wr_data[31:0] != UNLOCK_KEY) |=> locked_o); // R2
endmodule

// File: rtl/xtrig_regs.sv
module xtrig_regs #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int NCH   = 4,
  parameter int NTRIG = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   locked,
  output logic                   ctrl_en,
  output logic [NCH-1:0]         gate,
  output logic [NTRIG*NCH-1:0]   en_flat,
  output logic [NCH-1:0]         pulse_req,
  output logic [DW-1:0]          rd_data
);
  import xtrig_pkg::*;

  localparam int PADW = DW - NCH;

  logic           wr_ok;
  logic           ctrl_q;
  logic [NCH-1:0] gate_q;
  logic [DW-1:0]  rd_next;
  logic [DW-1:0]  rd_q;

  assign wr_ok = wr_en && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      gate_q <= '0;
    end else if (wr_ok) begin
      if (addr == AW'(OFF_CTRL)) ctrl_q <= wr_data[0];
      if (addr == AW'(OFF_GATE)) gate_q <= wr_data[NCH-1:0];
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NTRIG; gi++) begin : g_sel
      logic [NCH-1:0] sel_q;
      always_ff @(posedge clk) begin
        if (rst)
          sel_q <= '0;
        else if (wr_ok && addr == AW'(OFF_EN_BASE + 4*gi))
          sel_q <= wr_data[NCH-1:0];
      end
      assign en_flat[gi*NCH +: NCH] = sel_q;
    end
  endgenerate

  assign pulse_req = (wr_ok && addr == AW'(OFF_PULSE)) ? wr_data[NCH-1:0] : '0;

  always_comb begin
    rd_next = '0;
    if (addr == AW'(OFF_CTRL)) rd_next = DW'(ctrl_q);
    if (addr == AW'(OFF_GATE)) rd_next = {{PADW{1'b0}}, gate_q};
    for (int n = 0; n < NTRIG; n++)
      if (addr == AW'(OFF_EN_BASE + 4*n))
        rd_next = {{PADW{1'b0}}, en_flat[n*NCH +: NCH]};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign ctrl_en = ctrl_q;
  assign gate    = gate_q;
  assign rd_data = rd_q;

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    locked |=> ($stable(ctrl_en) && $stable(gate) && $stable(en_flat))); // R1
  AST_LOCKED_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    locked |-> (pulse_req == '0)); // R1
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int NCH   = 4,
  parameter int NTRIG = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctrl_en,
  input  logic [NCH-1:0]       gate,
  input  logic [NTRIG*NCH-1:0] en_flat,
  input  logic [NCH-1:0]       pulse_req,
  input  logic [NCH-1:0]       chan_in,
  output logic [NCH-1:0]       chan_out,
  output logic [NTRIG-1:0]     trig_out
);
  logic [NCH-1:0]   sw_q;
  logic [NCH-1:0]   ch_live;
  logic [NCH-1:0]   chan_q;
  logic [NTRIG-1:0] trig_next;
  logic [NTRIG-1:0] trig_q;

  assign ch_live = chan_in | sw_q;

  genvar gi;
  generate
    for (gi = 0; gi < NTRIG; gi++) begin : g_map
      assign trig_next[gi] = ctrl_en && |(en_flat[gi*NCH +: NCH] & ch_live);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= '0;
      chan_q <= '0;
      trig_q <= '0;
    end else begin
      sw_q   <= pulse_req;
      chan_q <= ctrl_en ? (sw_q & gate) : '0;
      trig_q <= trig_next;
    end
  end

  assign chan_out = chan_q;
  assign trig_out = trig_q;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl_en |=> (trig_out == '0 && chan_out == '0)); // R3
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((chan_out & ~$past(gate)) == '0)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (pulse_req == '0) |=> ##1 (chan_out == '0)); // R6
  AST_NO_ECHO: assert property (@(posedge clk) disable iff (rst)
    (pulse_req == '0 && chan_in != '0) |=> ##1 ((chan_out & $past(chan_in)) == '0)); // R5
endmodule

// File: rtl/xtrig_hub.sv
module xtrig_hub #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int NCH   = 4,
  parameter int NTRIG = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NCH-1:0]   chan_in,
  output logic [NCH-1:0]   chan_out,
  output logic [NTRIG-1:0] trig_out
);
  logic                 locked;
  logic                 ctrl_en;
  logic [NCH-1:0]       gate;
  logic [NTRIG*NCH-1:0] en_flat;
  logic [NCH-1:0]       pulse_req;

  xtrig_lock #(.AW(AW), .DW(DW)) u_lock (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .locked_o(locked)
  );

  xtrig_regs #(.AW(AW), .DW(DW), .NCH(NCH), .NTRIG(NTRIG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr),
    .wr_data(reg_wdata), .locked(locked), .ctrl_en(ctrl_en), .gate(gate),
    .en_flat(en_flat), .pulse_req(pulse_req), .rd_data(reg_rdata)
  );

  xtrig_route #(.NCH(NCH), .NTRIG(NTRIG)) u_route (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .gate(gate), .en_flat(en_flat),
    .pulse_req(pulse_req), .chan_in(chan_in), .chan_out(chan_out),
    .trig_out(trig_out)
  );
endmodule

// File: tb/xtrig_hub_tb.sv
module xtrig_hub_tb;
  localparam int NCH = 4;
  localparam int NT  = 14;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  chan_in = '0;
  logic [3:0]  chan_out;
  logic [13:0] trig_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int sel_m [NT];

  always #10 clk = ~clk;

  xtrig_hub u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .chan_in(chan_in),
    .chan_out(chan_out), .trig_out(trig_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 12'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic [13:0] map_exp(input logic [3:0] ch);
    logic [13:0] r = '0;
    for (int n = 0; n < NT; n++)
      r[n] = ((sel_m[n] & int'(ch)) != 0);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < NT; n++) sel_m[n] = (n + 1) & 'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    @(negedge clk);
    check("R9", 32'(trig_out), 32'h0);
    check("R9", 32'(chan_out), 32'h0);
    rd('h000, v); check("R9", v, 32'h0);
    rd('h140, v); check("R9", v, 32'h0);
    for (int n = 0; n < NT; n++) begin
      rd('h0A0 + 4*n, v); check("R9", v, 32'h0);
    end

    // R1: locked writes dropped
    wr('h000, 32'h1); wr('h140, 32'hF); wr('h0A0, 32'h1);
    rd('h000, v); check("R1", v, 32'h0);
    rd('h140, v); check("R1", v, 32'h0);
    rd('h0A0, v); check("R1", v, 32'h0);
    wr('h01C, 32'hF);
    @(negedge clk);
    check("R1", 32'(chan_out), 32'h0);

    // R2: unlock
    wr('hFB0, KEY);
    wr('h000, 32'h1);
    rd('h000, v); check("R2", v, 32'h1);

    // R4/R8: program selects, read back masked
    for (int n = 0; n < NT; n++) wr('h0A0 + 4*n, 32'(sel_m[n]) | 32'hFFF0_0000);
    for (int n = 0; n < NT; n++) begin
      rd('h0A0 + 4*n, v); check("R4", v, 32'(sel_m[n]));
    end

    // R4: incoming channel sweep, not echoed (R5)
    for (int ci = 0; ci < 16; ci++) begin
      @(negedge clk); chan_in = 4'(ci);
      @(negedge clk); chan_in = '0;
      check("R4", 32'(trig_out), 32'(map_exp(4'(ci))));
      check("R5", 32'(chan_out), 32'h0);
      @(negedge clk);
      check("R4", 32'(trig_out), 32'h0);
    end

    // R5/R6: gate x pulse sweep
    for (int g = 0; g < 16; g++) begin
      wr('h140, 32'(g));
      for (int p = 0; p < 16; p++) begin
        wr('h01C, 32'(p));
        @(negedge clk);
        check("R5", 32'(chan_out), 32'(p & g));
        check("R6", 32'(trig_out), 32'(map_exp(4'(p))));
        @(negedge clk);
        check("R6", 32'(chan_out), 32'h0);
        check("R6", 32'(trig_out), 32'h0);
      end
    end

    // R7: local pulse ORed with incoming in the same cycle
    wr('h01C, 32'h1);
    chan_in = 4'h8;
    @(negedge clk); chan_in = '0;
    check("R7", 32'(trig_out), 32'(map_exp(4'h9)));

    // R3: disabled block stays quiet
    wr('h000, 32'h0);
    @(negedge clk); chan_in = 4'hF;
    @(negedge clk); chan_in = '0;
    check("R3", 32'(trig_out), 32'h0);
    wr('h01C, 32'hF);
    @(negedge clk);
    check("R3", 32'(chan_out), 32'h0);
    check("R3", 32'(trig_out), 32'h0);
    wr('h000, 32'h1);

    // R8: unmapped and write-only offsets read zero
    rd('h004, v); check("R8", v, 32'h0);
    rd('h09C, v); check("R8", v, 32'h0);
    rd('h0A0 + 4*NT, v); check("R8", v, 32'h0);
    rd('h200, v); check("R8", v, 32'h0);
    rd('h01C, v); check("R8", v, 32'h0);
    rd('hFB0, v); check("R8", v, 32'h0);

    // R2: bad key relocks; R1 writes then dropped; R8 reads still work
    wr('hFB0, 32'h1234_5678);
    wr('h000, 32'h0);
    wr('h0A0, 32'h0);
    rd('h000, v); check("R2", v, 32'h1);
    rd('h0A0, v); check("R8", v, 32'(sel_m[0]));
    @(negedge clk); chan_in = 4'h1;
    @(negedge clk); chan_in = '0;
    check("R1", 32'(trig_out), 32'(map_exp(4'h1)));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule